// File: doc/BRIEF.md
# RV32I Immediate Generator

This block takes one 32-bit RV32I instruction word and produces two things in the same cycle: the immediate operand, sign-extended to the datapath width, and a small code naming the instruction format. The format is decoded from the 7-bit opcode alone. The five immediate-carrying layouts (I, S, B, U, J) are each reassembled from their scattered bit fields. The B and J layouts get an implicit zero in bit 0.

The block is purely combinational and holds no state. A decode stage places it beside the register-field extraction and feeds its outputs to operand selection. Any opcode that carries no immediate yields a zero immediate and the "none" code. This covers register-register operations and unknown encodings.

Top module: `rv_imm_gen`

## Requirements
- R1: Opcodes 7'b0010011, 7'b0000011 and 7'b1100111 give format code 1 (I). The immediate is instr[31:20] sign-extended, so it equals the bit field in imm[11:0].
- R2: Opcode 7'b0100011 gives format code 2 (S). The immediate is {instr[31:25], instr[11:7]} sign-extended: imm[11:5] comes from instr[31:25] and imm[4:0] from instr[11:7].
- R3: Opcode 7'b1100011 gives format code 3 (B). The immediate is {instr[31], instr[7], instr[30:25], instr[11:8], 0} sign-extended, so imm[0] is always 0.
- R4: Opcodes 7'b0110111 and 7'b0010111 give format code 4 (U). The immediate is instr[31:12] in bits 31:12, and imm[11:0] is always zero.
- R5: Opcode 7'b1101111 gives format code 5 (J). The immediate is {instr[31], instr[19:12], instr[20], instr[30:21], 0} sign-extended, so imm[0] is always 0.
- R6: Every other opcode, including 7'b0110011 and 7'b0000000, gives format code 0 (none) and an all-zero immediate.
- R7: For every format other than none, every immediate bit above the format's top field bit equals instr[31]. This holds even for instructions that use the value as unsigned; for example, SLTIU with an all-ones field gives 32'hFFFFFFFF.
- R8: Instruction bits that are register or function fields in a format, and carry no immediate bits there, have no effect on the immediate. These are instr[19:7] for I, instr[19:12] for S and B, and instr[11:7] for U and J.
- R9: The outputs depend only on the current instruction word and settle in the same cycle. No clock or reset is involved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_i | input | 32 | Instruction word being decoded |
| imm_o | output | XLEN (32) | Sign-extended immediate, zero when the format is none |
| fmt_o | output | 3 | Format code: 0 none, 1 I, 2 S, 3 B, 4 U, 5 J |

## Verification
The block holds no state, so a wrong internal value cannot linger or build up. It shows at the ports in the same evaluation as the instruction that exposes it. A wrong opcode decode shows as a wrong format code, and usually as a zero or wrongly shaped immediate. A misrouted bit shows only for instruction words where that bit is set. For that reason the sweep crosses every opcode with walking-one, all-zero, all-ones and pseudo-random payloads. The extreme positive and negative offsets of each format are also checked against hand-assembled words.

// File: rtl/rv_imm_pkg.sv
package rv_imm_pkg;

    // Format code driven on fmt_o
    typedef enum logic [2:0] {
        FMT_NONE = 3'd0,
        FMT_I    = 3'd1,
        FMT_S    = 3'd2,
        FMT_B    = 3'd3,
        FMT_U    = 3'd4,
        FMT_J    = 3'd5
    } imm_fmt_e;

    localparam int unsigned INSN_W = 32;
    localparam int unsigned OPC_W  = 7;

    // Opcodes that carry an immediate
    localparam logic [OPC_W-1:0] OPC_ARITH_IMM = 7'b0010011;
    localparam logic [OPC_W-1:0] OPC_LOAD      = 7'b0000011;
    localparam logic [OPC_W-1:0] OPC_JUMP_REG  = 7'b1100111;
    localparam logic [OPC_W-1:0] OPC_STORE     = 7'b0100011;
    localparam logic [OPC_W-1:0] OPC_BRANCH    = 7'b1100011;
    localparam logic [OPC_W-1:0] OPC_UPPER     = 7'b0110111;
    localparam logic [OPC_W-1:0] OPC_UPPER_PC  = 7'b0010111;
    localparam logic [OPC_W-1:0] OPC_JUMP      = 7'b1101111;

endpackage

// File: rtl/rv_imm_opdec.sv
module rv_imm_opdec
    import rv_imm_pkg::*;
(
    input  logic [OPC_W-1:0] opcode_i,
    output imm_fmt_e         fmt_o
);

    always_comb begin
        unique case (opcode_i)
            OPC_ARITH_IMM,
            OPC_LOAD,
            OPC_JUMP_REG:  fmt_o = FMT_I;
            OPC_STORE:     fmt_o = FMT_S;
            OPC_BRANCH:    fmt_o = FMT_B;
            OPC_UPPER,
            OPC_UPPER_PC:  fmt_o = FMT_U;
            OPC_JUMP:      fmt_o = FMT_J;
            default:       fmt_o = FMT_NONE;
        endcase
    end

endmodule

// File: rtl/rv_imm_fields.sv
module rv_imm_fields
    import rv_imm_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic [INSN_W-1:7] payload_i,
    output logic [XLEN-1:0]   imm_i_o,
    output logic [XLEN-1:0]   imm_s_o,
    output logic [XLEN-1:0]   imm_b_o,
    output logic [XLEN-1:0]   imm_u_o,
    output logic [XLEN-1:0]   imm_j_o
);

    // Raw widths of each reassembled field (sign bit included)
    localparam int unsigned W12 = 12;
    localparam int unsigned W13 = 13;
    localparam int unsigned W21 = 21;
    localparam int unsigned W32 = 32;

    logic            sgn;
    logic [W12-1:0]  raw_i;
    logic [W12-1:0]  raw_s;
    logic [W13-1:0]  raw_b;
    logic [W32-1:0]  raw_u;
    logic [W21-1:0]  raw_j;

    assign sgn   = payload_i[31];
    assign raw_i = payload_i[31:20];
    assign raw_s = {payload_i[31:25], payload_i[11:7]};
    assign raw_b = {payload_i[31], payload_i[7], payload_i[30:25], payload_i[11:8], 1'b0};
    assign raw_u = {payload_i[31:12], 12'h000};
    assign raw_j = {payload_i[31], payload_i[19:12], payload_i[20], payload_i[30:21], 1'b0};

    assign imm_i_o = {{(XLEN-W12){sgn}}, raw_i};
    assign imm_s_o = {{(XLEN-W12){sgn}}, raw_s};
    assign imm_b_o = {{(XLEN-W13){sgn}}, raw_b};
    assign imm_j_o = {{(XLEN-W21){sgn}}, raw_j};

    // U needs extension only when the datapath is wider than the word
    generate
        if (XLEN > W32) begin : g_u_wide
            assign imm_u_o = {{(XLEN-W32){sgn}}, raw_u};
        end else begin : g_u_exact
            assign imm_u_o = raw_u;
        end
    endgenerate

endmodule

// File: rtl/rv_imm_select.sv
module rv_imm_select
    import rv_imm_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  imm_fmt_e        fmt_i,
    input  logic [XLEN-1:0] imm_i_i,
    input  logic [XLEN-1:0] imm_s_i,
    input  logic [XLEN-1:0] imm_b_i,
    input  logic [XLEN-1:0] imm_u_i,
    input  logic [XLEN-1:0] imm_j_i,
    output logic [XLEN-1:0] imm_o
);

    always_comb begin
        unique case (fmt_i)
            FMT_I:   imm_o = imm_i_i;
            FMT_S:   imm_o = imm_s_i;
            FMT_B:   imm_o = imm_b_i;
            FMT_U:   imm_o = imm_u_i;
            FMT_J:   imm_o = imm_j_i;
            default: imm_o = '0;
        endcase
    end

endmodule

// File: rtl/rv_imm_gen.sv
module rv_imm_gen
    import rv_imm_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic [31:0]     instr_i,
    output logic [XLEN-1:0] imm_o,
    output logic [2:0]      fmt_o
);

    imm_fmt_e        fmt;
    logic [XLEN-1:0] c_i;
    logic [XLEN-1:0] c_s;
    logic [XLEN-1:0] c_b;
    logic [XLEN-1:0] c_u;
    logic [XLEN-1:0] c_j;

    rv_imm_opdec u_opdec (
        .opcode_i (instr_i[OPC_W-1:0]),
        .fmt_o    (fmt)
    );

    rv_imm_fields #(.XLEN(XLEN)) u_fields (
        .payload_i (instr_i[INSN_W-1:7]),
        .imm_i_o   (c_i),
        .imm_s_o   (c_s),
        .imm_b_o   (c_b),
        .imm_u_o   (c_u),
        .imm_j_o   (c_j)
    );

    rv_imm_select #(.XLEN(XLEN)) u_select (
        .fmt_i   (fmt),
        .imm_i_i (c_i),
        .imm_s_i (c_s),
        .imm_b_i (c_b),
        .imm_u_i (c_u),
        .imm_j_i (c_j),
        .imm_o   (imm_o)
    );

    assign fmt_o = fmt;

endmodule

// File: rtl/rv_imm_gen_chk.sv
module rv_imm_gen_chk #(
    parameter int unsigned XLEN = 32
) (
    input logic [31:0]     instr_i,
    input logic [XLEN-1:0] imm_o,
    input logic [2:0]      fmt_o
);

    always_comb begin
        assert_fmt_range_R6: assert (fmt_o <= 3'd5);
        assert_rtype_none_R6: assert (instr_i[6:0] != 7'b0110011 || fmt_o == 3'd0);
        assert_none_zero_R6: assert (fmt_o != 3'd0 || imm_o == '0);
        assert_sign_top_R7: assert (fmt_o == 3'd0 || imm_o[XLEN-1] == instr_i[31]);
        assert_i_field_R1: assert (fmt_o != 3'd1 || imm_o[11:0] == instr_i[31:20]);
        assert_s_field_R2: assert (fmt_o != 3'd2 ||
                                   {imm_o[11:5], imm_o[4:0]} == {instr_i[31:25], instr_i[11:7]});
        assert_b_lsb_R3: assert (fmt_o != 3'd3 || (imm_o[0] == 1'b0 && imm_o[11] == instr_i[7]));
        assert_u_low_R4: assert (fmt_o != 3'd4 || imm_o[11:0] == 12'h000);
        assert_j_lsb_R5: assert (fmt_o != 3'd5 ||
                                 (imm_o[0] == 1'b0 && imm_o[19:12] == instr_i[19:12]));
    end

endmodule

bind rv_imm_gen rv_imm_gen_chk #(.XLEN(XLEN)) u_chk (
    .instr_i (instr_i),
    .imm_o   (imm_o),
    .fmt_o   (fmt_o)
);

// File: tb/rv_imm_gen_test.sv
module rv_imm_gen_test;

    logic        clk = 1'b0;
    logic [31:0] instr;
    logic [31:0] imm;
    logic [2:0]  fmt;
    int          n_chk = 0;
    int          n_err = 0;
    bit          done  = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    rv_imm_gen #(.XLEN(32)) uut (
        .instr_i (instr),
        .imm_o   (imm),
        .fmt_o   (fmt)
    );

    function automatic logic [2:0] exp_fmt(input logic [6:0] op);
        case (op)
            7'b0010011, 7'b0000011, 7'b1100111: return 3'd1;
            7'b0100011:                         return 3'd2;
            7'b1100011:                         return 3'd3;
            7'b0110111, 7'b0010111:             return 3'd4;
            7'b1101111:                         return 3'd5;
            default:                            return 3'd0;
        endcase
    endfunction

    function automatic logic [31:0] exp_imm(input logic [31:0] w);
        logic [31:0] v;
        logic        neg;
        neg = w[31];
        case (exp_fmt(w[6:0]))
            3'd1: begin
                v = w >> 20;
                if (neg) v = v | 32'hFFFF_F000;
            end
            3'd2: begin
                v = ((w >> 25) << 5) | ((w >> 7) & 32'd31);
                if (neg) v = v | 32'hFFFF_F000;
            end
            3'd3: begin
                v = (((w >> 7) & 32'd1) << 11) | (((w >> 25) & 32'd63) << 5)
                  | (((w >> 8) & 32'd15) << 1);
                if (neg) v = v | 32'hFFFF_F000;
            end
            3'd4: v = w & 32'hFFFF_F000;
            3'd5: begin
                v = (((w >> 21) & 32'd1023) << 1) | (((w >> 20) & 32'd1) << 11)
                  | (w & 32'h000F_F000);
                if (neg) v = v | 32'hFFF0_0000;
            end
            default: v = 32'd0;
        endcase
        return v;
    endfunction

    task automatic apply(input logic [31:0] w);
        @(negedge clk);
        instr = w;
        #2;
    endtask

    task automatic check_val(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s instr=%08h actual=%08h expected=%08h", req, instr, act, exp);
        end
    endtask

    function automatic string req_of(input logic [2:0] f);
        case (f)
            3'd1:    return "R1";
            3'd2:    return "R2";
            3'd3:    return "R3";
            3'd4:    return "R4";
            3'd5:    return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic hand(input logic [31:0] w, input logic [2:0] f, input logic [31:0] v,
                        input string req);
        apply(w);
        check_val(req, {29'd0, fmt}, {29'd0, f});
        check_val(req, imm, v);
    endtask

    // R8: flipping non-immediate field bits must leave the immediate unchanged
    task automatic field_blind(input logic [31:0] base, input logic [31:0] mask);
        logic [31:0] ref_imm;
        apply(base);
        ref_imm = imm;
        apply(base ^ mask);
        check_val("R8", imm, ref_imm);
        check_val("R8", imm, exp_imm(base));
    endtask

    initial begin
        logic [31:0] rnd;
        instr = 32'd0;
        #3;
        // R9 / R6: all-zero word, outputs settle without any clock
        check_val("R9", {29'd0, fmt}, 32'd0);
        check_val("R6", imm, 32'd0);

        // Hand-assembled extremes
        hand(32'h8000_0093, 3'd1, 32'hFFFF_F800, "R1");   // addi -2048
        hand(32'h7FF0_0093, 3'd1, 32'h0000_07FF, "R1");   // addi +2047
        hand(32'hFFF0_3093, 3'd1, 32'hFFFF_FFFF, "R7");   // sltiu -1
        hand(32'h8000_2023, 3'd2, 32'hFFFF_F800, "R2");   // sw -2048
        hand(32'h7E00_2FA3, 3'd2, 32'h0000_07FF, "R2");   // sw +2047
        hand(32'h8000_0063, 3'd3, 32'hFFFF_F000, "R3");   // beq -4096
        hand(32'h7E00_0FE3, 3'd3, 32'h0000_0FFE, "R3");   // beq +4094
        hand(32'hFFFF_F037, 3'd4, 32'hFFFF_F000, "R4");   // lui top
        hand(32'h7FFF_F017, 3'd4, 32'h7FFF_F000, "R4");   // auipc max
        hand(32'h8000_006F, 3'd5, 32'hFFF0_0000, "R5");   // jal -1 MiB
        hand(32'h7FFF_F06F, 3'd5, 32'h000F_FFFE, "R5");   // jal max
        hand(32'hFFFF_FFB3, 3'd0, 32'h0000_0000, "R6");   // register-register op

        // R8: register/function fields ignored
        field_blind(32'h8000_0013, 32'h000F_FF80);        // I: bits 19:7
        field_blind(32'hFE00_0FA3, 32'h000F_F000);        // S: bits 19:12
        field_blind(32'h7E00_0F63, 32'h000F_F000);        // B: bits 19:12
        field_blind(32'hABCD_E037, 32'h0000_0F80);        // U: bits 11:7
        field_blind(32'h8765_406F, 32'h0000_0F80);        // J: bits 11:7

        // Sweep: every opcode crossed with 40 payload patterns
        rnd = 32'h1234_5679;
        for (int op = 0; op < 128; op++) begin
            for (int k = 0; k < 40; k++) begin
                logic [31:0] pay;
                logic [2:0]  f;
                if (k == 0)       pay = 32'd0;
                else if (k == 1)  pay = 32'hFFFF_FFFF;
                else if (k < 27)  pay = 32'd1 << (k + 5);
                else begin
                    rnd = rnd ^ (rnd << 13);
                    rnd = rnd ^ (rnd >> 17);
                    rnd = rnd ^ (rnd << 5);
                    pay = rnd;
                end
                apply({pay[31:7], op[6:0]});
                f = exp_fmt(op[6:0]);
                check_val(req_of(f), {29'd0, fmt}, {29'd0, f});
                check_val(f == 3'd0 ? "R6" : "R7", imm, exp_imm(instr));
            end
        end

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule